// File: doc/BRIEF.md
# Length-Framed Stream Accumulator

This block is a streaming processing element that sits on a 64-bit word stream with valid/ready handshakes on both sides. Each incoming frame opens with one word giving, as an unsigned count, how many payload words follow. The block adds exactly that many payload words into a 64-bit sum that starts from zero for every frame. It then replies with a two-word frame: a header word holding the value 1, followed by the sum.

Routing headers are stripped before data reaches the block, so the first word after reset, and the first word after each reply, is always a length. The block works on one frame at a time. While the reply is being sent, the input side is closed. The next length word is taken only after the downstream side has accepted both reply words. Backpressure on the output therefore throttles the input, and no word is dropped. The design is meant to run at 250 MHz. Every path is a single register stage with an adder or a comparator in front of it.

Top module: `frame_sum_pe`

## Requirements
- R1: After reset is released, `out_valid` is 0 and `in_ready` is 1, with the block waiting for a length word.
- R2: The first word accepted in a frame is taken as an unsigned payload count N. Exactly N more words are accepted as payload. After the Nth payload handshake, `in_ready` is 0 in the next cycle.
- R3: The reply sum is the modulo-2^64 total of that frame's N payload words. It wraps on overflow with no flag, and it starts from zero for every frame.
- R4: Every reply is two words, in this order: first a header word equal to 1, then the sum. The header is always presented before the sum.
- R5: A frame with N = 0 takes no payload words. The next cycle it presents the reply words 1 and 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value in the next cycle.
- R7: `in_ready` is 0 whenever `out_valid` is 1. Words driven on the input during the reply are not taken and have no effect on any later reply.
- R8: Only cycles with both `in_valid` and `in_ready` high count as accepted input. Idle gaps between payload words change neither the count nor the sum.
- R9: In the cycle after the sum word's handshake, `out_valid` is 0 and `in_ready` is 1, ready for the next length word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 64 | Input word: length, then payload |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept an input word |
| out_data | output | 64 | Reply word: header 1, then sum |
| out_valid | output | 1 | Reply word present |
| out_ready | input | 1 | Downstream accepts the reply word |

## Verification
Two things happen in the same clock edge: the addition of the final payload word and the switch from collecting input to presenting the reply. The bench provokes this by holding `in_valid` high through back-to-back payload words. It also provokes it with a zero length, where the length handshake itself starts the reply. The result is judged by checking the sum, which must include the last word, and by checking that `in_ready` is already low one cycle after that edge. A second overlap happens when the downstream side stalls while the input side is pushing a stray word. That case is judged by the held `out_data` and by an undisturbed sum in the next frame.

// File: rtl/fsp_pkg.sv
// Shared types for the length-framed stream accumulator.
// Assumes nothing beyond the parameters of the top module.
package fsp_pkg;

    // Frame phases: take length, take payload, send header, send sum.
    typedef enum logic [1:0] {
        ST_LEN = 2'd0,
        ST_PAY = 2'd1,
        ST_HDR = 2'd2,
        ST_SUM = 2'd3
    } fsp_state_t;

endpackage

// File: rtl/fsp_ctrl.sv
// Frame sequencer: counts payload words against the leading length,
// then sequences the two reply words. Assumes the length word is the
// first word of every frame and that the reply words leave in order.
module fsp_ctrl
    import fsp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              sel_sum,
    output logic              clear_sum,
    output logic              add_en
);

    fsp_state_t        state;
    fsp_state_t        state_nx;
    logic [DATA_W-1:0] remain;
    logic              in_fire;
    logic              out_fire;
    logic              last_pay;

    // Handshake and phase decode.
    always_comb begin
        in_ready  = (state == ST_LEN) || (state == ST_PAY);
        out_valid = (state == ST_HDR) || (state == ST_SUM);
        sel_sum   = (state == ST_SUM);
        in_fire   = in_valid && in_ready;
        out_fire  = out_valid && out_ready;
        clear_sum = (state == ST_LEN) && in_fire;
        add_en    = (state == ST_PAY) && in_fire;
        last_pay  = add_en && (remain == DATA_W'(1));
    end

    // Next-phase selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LEN: if (in_fire)  state_nx = (in_data == '0) ? ST_HDR : ST_PAY;
            ST_PAY: if (last_pay) state_nx = ST_HDR;
            ST_HDR: if (out_fire) state_nx = ST_SUM;
            ST_SUM: if (out_fire) state_nx = ST_LEN;
            default:              state_nx = ST_LEN;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LEN;
        else        state <= state_nx;
    end

    // Remaining payload word counter.
    always_ff @(posedge clk) begin
        if (!rst_n)         remain <= '0;
        else if (clear_sum) remain <= in_data;
        else if (add_en)    remain <= remain - DATA_W'(1);
    end

endmodule

// File: rtl/fsp_accum.sv
// Running sum register: cleared on each length word, adds each
// accepted payload word modulo 2^DATA_W. Assumes clear and add never
// assert together (length and payload are separate phases).
module fsp_accum #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_sum,
    input  logic              add_en,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] sum
);

    // Sum register with per-frame clear and wrap-around add.
    always_ff @(posedge clk) begin
        if (!rst_n)         sum <= '0;
        else if (clear_sum) sum <= '0;
        else if (add_en)    sum <= sum + in_data;
    end

endmodule

// File: rtl/fsp_tx.sv
// Reply word selector: presents the constant header value, then the
// sum. Assumes the sum is stable while the reply is being sent.
module fsp_tx #(
    parameter int DATA_W  = 64,
    parameter int HDR_VAL = 1
) (
    input  logic              sel_sum,
    input  logic [DATA_W-1:0] sum,
    output logic [DATA_W-1:0] out_data
);

    localparam logic [DATA_W-1:0] HDR_WORD = DATA_W'(HDR_VAL);

    // Choose header or sum for the output word.
    always_comb begin
        out_data = sel_sum ? sum : HDR_WORD;
    end

endmodule

// File: rtl/frame_sum_pe.sv
// Length-framed stream accumulator top. Takes a length word and that
// many payload words, replies with header 1 and the payload sum.
// Assumes routing headers are removed upstream.
module frame_sum_pe #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);

    localparam int REPLY_LEN = 1;

    logic              sel_sum;
    logic              clear_sum;
    logic              add_en;
    logic [DATA_W-1:0] sum;

    fsp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .sel_sum   (sel_sum),
        .clear_sum (clear_sum),
        .add_en    (add_en)
    );

    fsp_accum #(.DATA_W(DATA_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_sum (clear_sum),
        .add_en    (add_en),
        .in_data   (in_data),
        .sum       (sum)
    );

    fsp_tx #(.DATA_W(DATA_W), .HDR_VAL(REPLY_LEN)) u_tx (
        .sel_sum  (sel_sum),
        .sum      (sum),
        .out_data (out_data)
    );

endmodule

// File: rtl/fsp_checker.sv
// Protocol checker for frame_sum_pe. Keeps its own model of the frame
// count, the sum and the reply order, taken from the port traffic only.
module fsp_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] in_data,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_ready
);

    logic              m_want_len;
    logic [DATA_W-1:0] m_len;
    logic [DATA_W-1:0] m_cnt;
    logic [DATA_W-1:0] m_sum;
    logic              m_hdr_next;
    logic              i_fire;
    logic              o_fire;

    assign i_fire = in_valid && in_ready;
    assign o_fire = out_valid && out_ready;

    // Reference model of input framing and sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_want_len <= 1'b1;
            m_len      <= '0;
            m_cnt      <= '0;
            m_sum      <= '0;
        end else if (i_fire && m_want_len) begin
            m_len      <= in_data;
            m_cnt      <= '0;
            m_sum      <= '0;
            m_want_len <= 1'b0;
        end else if (i_fire) begin
            m_cnt <= m_cnt + DATA_W'(1);
            m_sum <= m_sum + in_data;
        end else if (o_fire && !m_hdr_next) begin
            m_want_len <= 1'b1;
        end
    end

    // Reference model of the reply word order.
    always_ff @(posedge clk) begin
        if (!rst_n)      m_hdr_next <= 1'b1;
        else if (o_fire) m_hdr_next <= !m_hdr_next;
    end

    // R1: idle after reset.
    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid && in_ready));

    // R2, R5: reply starts only once exactly N payload words are taken.
    a_r2_count_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (m_cnt == m_len));

    // R3: sum word matches the modelled modulo sum.
    a_r3_sum_match: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !m_hdr_next) |-> (out_data == m_sum));

    // R4: header word first, valued 1.
    a_r4_header_first: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && m_hdr_next) |-> (out_data == DATA_W'(1)));

    // R6: reply held under backpressure.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7: input closed while replying.
    a_r7_input_closed: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R9: input reopens right after the sum word leaves.
    a_r9_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        (o_fire && !m_hdr_next) |=> (in_ready && !out_valid));

endmodule

bind frame_sum_pe fsp_checker #(.DATA_W(DATA_W)) u_fsp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready)
);

// File: tb/frame_sum_pe_bench.sv
`timescale 1ns/1ps
module frame_sum_pe_bench;

    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] out_data;
    logic         out_valid;
    logic         out_ready = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    frame_sum_pe #(.DATA_W(W)) u_frame_sum_pe (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Push one input word after a number of idle cycles.
    task automatic send_word(input logic [W-1:0] d, input int gap);
        repeat (gap) @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_data  = '0;
    endtask

    // Take one reply word after stalling; optionally push a stray input word.
    task automatic recv_word(input logic [W-1:0] exp, input int stall,
                             input bit junk, input bit is_sum);
        @(negedge clk);
        if (junk) begin
            in_valid = 1'b1;
            in_data  = 64'hDEAD_BEEF_0BAD_F00D;
        end
        for (int k = 0; k < stall; k++) begin
            check("R6 valid held", W'(out_valid), W'(1));
            check("R6 data held", out_data, exp);
            check("R7 input closed", W'(in_ready), W'(0));
            @(negedge clk);
        end
        in_valid  = 1'b0;
        in_data   = '0;
        out_ready = 1'b1;
        check("R4 word present", W'(out_valid), W'(1));
        check(is_sum ? "R3 sum word" : "R4 header word", out_data, exp);
        @(posedge clk);
        #1;
        out_ready = 1'b0;
        if (is_sum) begin
            check("R9 input reopened", W'(in_ready), W'(1));
            check("R9 output idle", W'(out_valid), W'(0));
        end
    endtask

    // Send a whole frame, then collect and judge its reply.
    task automatic run_frame(input string name, input logic [W-1:0] words[],
                             input int gap, input int stall, input bit junk);
        logic [W-1:0] total = '0;
        send_word(W'(words.size()), 0);
        foreach (words[i]) begin
            send_word(words[i], gap);
            total += words[i];
        end
        check("R2 input closed after last payload", W'(in_ready), W'(0));
        recv_word(W'(1), stall, junk, 1'b0);
        recv_word(total, stall, 1'b0, 1'b1);
        $display("frame %s done", name);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 out_valid after reset", W'(out_valid), W'(0));
        check("R1 in_ready after reset", W'(in_ready), W'(1));
    endtask

    task automatic t_basic;
        logic [W-1:0] w[] = '{64'd10, 64'd20, 64'd30};
        run_frame("basic R2 R3", w, 0, 0, 1'b0);
    endtask

    task automatic t_zero;
        send_word('0, 0);
        check("R5 reply ready after zero length", W'(out_valid), W'(1));
        check("R5 input closed", W'(in_ready), W'(0));
        recv_word(W'(1), 0, 1'b0, 1'b0);
        recv_word(W'(0), 0, 1'b0, 1'b1);
    endtask

    task automatic t_wrap;
        logic [W-1:0] w[] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'd2};
        run_frame("wrap R3", w, 0, 1, 1'b0);
    endtask

    task automatic t_gaps_stall;
        logic [W-1:0] w[] = '{64'd1, 64'd2, 64'd3, 64'd4, 64'h1_0000_0000};
        run_frame("gaps R8 stall R6 junk R7", w, 3, 4, 1'b1);
    endtask

    task automatic t_restart;
        logic [W-1:0] w[] = '{64'd7};
        run_frame("restart R3 R7", w, 0, 2, 1'b0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_zero();
        t_wrap();
        t_gaps_stall();
        t_restart();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule